// File: doc/BRIEF.md
# Zero-Overhead Loop and Return-Stack Program Sequencer

This block produces the fetch address for a simple in-order instruction stream. Each cycle it presents a fetch address and accepts one decoded control command for the instruction now in the execute slot, which is the instruction fetched two cycles earlier. The command can start a hardware loop, call a subroutine, return from one, or jump. Jumps, calls and returns can be unconditional or gated by an external condition or by the loop-counter-expired condition. Targets come from an immediate field, from a register value, or from an offset added to the execute-slot address.

Loops add no branch overhead. The fetch address is compared with the end address of the innermost active loop. On a match the sequencer either returns to the loop top and decrements the count, or leaves the loop and falls through. One 30-entry return stack holds both subroutine return addresses and loop-top addresses. A separate 6-entry loop-state stack holds each loop's end address, remaining count and the return-stack slot of its top. A taken jump, call or return discards the two younger instructions already in flight and raises a squash signal. A taken jump also ends the innermost active loop. Any push onto a full stack or pop from an empty one sets a sticky error flag and leaves that stack as it was.

Top module: `loop_seq`

## Requirements
- R1: While rst_ni is low, fetch_addr_o is 0, squash_o is 0 and stack_err_o is 0. Both stacks are empty after reset.
- R2: With no redirect and no loop wrap, fetch_addr_o rises by one each cycle. A command on cmd_i applies to the instruction fetched two cycles earlier, the execute slot. During the first two cycles after reset that slot is empty. Command codes are 0 nop, 1 jump, 2 call, 3 return and 4 loop start.
- R3: A loop start (code 4) takes its end address from addr_i and its count from count_i. Its top is the execute-slot address plus one. When the fetch address equals the end address and the count is above 1, the next fetch address is the loop top, the count drops by one and squash_o stays 0.
- R4: When the fetch address reaches the end address and the count is 1 or 0, the loop is removed from both stacks and fetching continues at the end address plus one. A count of 1 therefore runs the body once.
- R5: Loops nest up to 6 deep. When an inner loop finishes, the enclosing loop carries on with its own end address and remaining count.
- R6: A taken call (code 2) pushes the execute-slot address plus one and redirects to its target. A taken return (code 3) pops the return stack and redirects to the popped address.
- R7: The target select tsel_i chooses the target: 0 for addr_i, 1 for ind_addr_i, and 2 for the execute-slot address plus addr_i, modulo 2^AW.
- R8: The condition select csel_i chooses when a branch is taken: 0 always, 1 when cond_i is 1, 2 when the innermost active loop's count is 1 or less. A branch that is not taken has no effect.
- R9: A taken redirect drives squash_o high in the same cycle and sets the next fetch address to the target. Commands presented for the two squashed execute slots that follow are ignored.
- R10: A taken jump while a loop is active removes the innermost loop from the loop-state stack and removes its top from the return stack.
- R11: A push onto a full stack or a pop from an empty one sets stack_err_o from the next cycle until reset, and the stack is left unchanged. A return on an empty stack does not redirect. A call on a full stack still redirects.
- R12: The return stack is shared by calls and loops and holds exactly 30 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command for the execute-slot instruction |
| csel_i | input | 2 | Branch condition select |
| tsel_i | input | 2 | Branch target select |
| addr_i | input | AW | Direct target, relative offset or loop end address |
| ind_addr_i | input | AW | Register-sourced target |
| count_i | input | CW | Loop iteration count |
| cond_i | input | 1 | External condition |
| fetch_addr_o | output | AW | Address being fetched |
| squash_o | output | 1 | Discard the two younger in-flight instructions |
| stack_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The squash signal is combinational from the command and is sampled one time step after the inputs are driven in the same cycle. A redirect or loop wrap shows on fetch_addr_o at the next sample point, one clock later. The stack error flag is registered and is read one cycle after the offending command. The stimulus table is built cycle by cycle. Each command is placed only where the execute slot holds the intended instruction, which is two cycles after that instruction was fetched and never in a squashed slot. The directed tests then put commands into squashed slots on purpose and drive both stacks past their limits.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_JUMP = 3'd1,
    CMD_CALL = 3'd2,
    CMD_RTS  = 3'd3,
    CMD_LOOP = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    CND_ALWAYS = 2'd0,
    CND_TRUE   = 2'd1,
    CND_LCE    = 2'd2
  } cnd_e;

  typedef enum logic [1:0] {
    TGT_DIRECT   = 2'd0,
    TGT_INDIRECT = 2'd1,
    TGT_RELATIVE = 2'd2
  } tgt_e;
endpackage

// File: rtl/seq_lifo.sv
module seq_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 30,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          wr_top_i,
  input  logic [W-1:0]  data_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [W-1:0]  top_o,
  output logic [W-1:0]  rd_o,
  output logic [PW-1:0] ptr_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] top_idx;

  assign full_o  = (ptr_q == PW'(DEPTH));
  assign empty_o = (ptr_q == '0);
  assign top_idx = empty_o ? '0 : ptr_q - PW'(1);
  assign top_o   = mem_q[top_idx];
  assign rd_o    = mem_q[rd_idx_i];
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (push_i) begin
      ptr_q <= ptr_q + PW'(1);
    end else if (pop_i) begin
      ptr_q <= ptr_q - PW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      mem_q[ptr_q] <= data_i;
    end else if (wr_top_i) begin
      mem_q[top_idx] <= data_i;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R11
  AST_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)); // R12
  AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> ptr_q == $past(ptr_q) + PW'(1)); // R12
endmodule

// File: rtl/seq_branch.sv
module seq_branch
  import seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  cmd_e          cmd_i,
  input  cnd_e          csel_i,
  input  tgt_e          tsel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ind_addr_i,
  input  logic [AW-1:0] exec_pc_i,
  input  logic          valid_i,
  input  logic          cond_i,
  input  logic          lce_i,
  input  logic [AW-1:0] ret_top_i,
  input  logic          ret_empty_i,
  output logic          jump_o,
  output logic          call_o,
  output logic          rts_o,
  output logic          loop_o,
  output logic          redirect_o,
  output logic [AW-1:0] target_o
);
  cmd_e cmd;
  logic ok;

  always_comb begin
    cmd = valid_i ? cmd_i : CMD_NOP;
    unique case (csel_i)
      CND_TRUE: ok = cond_i;
      CND_LCE:  ok = lce_i;
      default:  ok = 1'b1;
    endcase
    jump_o = (cmd == CMD_JUMP) && ok;
    call_o = (cmd == CMD_CALL) && ok;
    rts_o  = (cmd == CMD_RTS) && ok;
    loop_o = (cmd == CMD_LOOP);
    redirect_o = jump_o || call_o || (rts_o && !ret_empty_i);
    if (rts_o) begin
      target_o = ret_top_i;
    end else begin
      unique case (tsel_i)
        TGT_INDIRECT: target_o = ind_addr_i;
        TGT_RELATIVE: target_o = exec_pc_i + addr_i;
        default:      target_o = addr_i;
      endcase
    end
  end
endmodule

// File: rtl/loop_seq.sv
module loop_seq
  import seq_pkg::*;
#(
  parameter int AW         = 16,
  parameter int CW         = 16,
  parameter int RET_DEPTH  = 30,
  parameter int LOOP_DEPTH = 6,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cmd_i,
  input  logic [1:0]    csel_i,
  input  logic [1:0]    tsel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ind_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic          cond_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          squash_o,
  output logic          stack_err_o
);
  localparam int RPW = $clog2(RET_DEPTH + 1);
  localparam int LPW = $clog2(LOOP_DEPTH + 1);
  localparam int LW  = RPW + AW + CW;

  // fetch / in-flight pipeline
  logic [AW-1:0] pc_q, p1_q, p2_q, pc_d;
  logic          v1_q, v2_q, err_q;

  // return stack
  logic          r_push, r_pop, r_full, r_empty;
  logic [AW-1:0] r_top, r_rd, r_data;
  logic [RPW-1:0] r_ptr;

  // loop-state stack
  logic          l_push, l_pop, l_wr, l_full, l_empty;
  logic [LW-1:0] l_top, l_data;
  logic [LPW-1:0] l_ptr;
  logic [RPW-1:0] l_idx;
  logic [AW-1:0] l_end;
  logic [CW-1:0] l_cnt;

  logic          jump_t, call_t, rts_t, loop_t, redirect;
  logic [AW-1:0] target;
  logic          loop_act, lce, at_end, wrap, expire, loop_ok, abort;
  logic          call_err, rts_err, loop_err;

  assign {l_idx, l_end, l_cnt} = l_top;
  assign loop_act = !l_empty;
  assign lce      = loop_act && (l_cnt <= CW'(1));

  seq_branch #(.AW(AW)) u_branch (
    .cmd_i       (cmd_e'(cmd_i)),
    .csel_i      (cnd_e'(csel_i)),
    .tsel_i      (tgt_e'(tsel_i)),
    .addr_i      (addr_i),
    .ind_addr_i  (ind_addr_i),
    .exec_pc_i   (p2_q),
    .valid_i     (v2_q),
    .cond_i      (cond_i),
    .lce_i       (lce),
    .ret_top_i   (r_top),
    .ret_empty_i (r_empty),
    .jump_o      (jump_t),
    .call_o      (call_t),
    .rts_o       (rts_t),
    .loop_o      (loop_t),
    .redirect_o  (redirect),
    .target_o    (target)
  );

  // loop end compare at fetch; execute-stage stack ops take priority
  assign at_end  = loop_act && (pc_q == l_end) && !redirect && !loop_t;
  assign wrap    = at_end && (l_cnt > CW'(1));
  assign expire  = at_end && !(l_cnt > CW'(1));
  assign loop_ok = loop_t && !r_full && !l_full;
  assign abort   = jump_t && loop_act;

  assign call_err = call_t && r_full;
  assign rts_err  = rts_t && r_empty;
  assign loop_err = loop_t && (r_full || l_full);

  assign r_push = (call_t && !r_full) || loop_ok;
  assign r_pop  = (rts_t && !r_empty) || abort || expire;
  assign r_data = p2_q + AW'(1);

  assign l_push = loop_ok;
  assign l_pop  = abort || expire;
  assign l_wr   = wrap;
  assign l_data = l_push ? {r_ptr, addr_i, count_i} : {l_idx, l_end, l_cnt - CW'(1)};

  seq_lifo #(.W(AW), .DEPTH(RET_DEPTH)) u_ret_stack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (r_push),
    .pop_i    (r_pop),
    .wr_top_i (1'b0),
    .data_i   (r_data),
    .rd_idx_i (l_idx),
    .top_o    (r_top),
    .rd_o     (r_rd),
    .ptr_o    (r_ptr),
    .full_o   (r_full),
    .empty_o  (r_empty)
  );

  seq_lifo #(.W(LW), .DEPTH(LOOP_DEPTH)) u_loop_stack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (l_push),
    .pop_i    (l_pop),
    .wr_top_i (l_wr),
    .data_i   (l_data),
    .rd_idx_i ('0),
    .top_o    (l_top),
    .rd_o     (),
    .ptr_o    (l_ptr),
    .full_o   (l_full),
    .empty_o  (l_empty)
  );

  always_comb begin
    if (redirect)  pc_d = target;
    else if (wrap) pc_d = r_rd;
    else           pc_d = pc_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_ADDR;
      p1_q  <= '0;
      p2_q  <= '0;
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      p1_q  <= pc_q;
      p2_q  <= p1_q;
      v1_q  <= !redirect;
      v2_q  <= v1_q && !redirect;
      err_q <= err_q || call_err || rts_err || loop_err;
    end
  end

  assign fetch_addr_o = pc_q;
  assign squash_o     = redirect;
  assign stack_err_o  = err_q;

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!squash_o && !wrap) |=> fetch_addr_o == $past(fetch_addr_o) + AW'(1)); // R2
  AST_LOOP_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> l_cnt == $past(l_cnt) - CW'(1)); // R3
  AST_WRAP_NO_SQUASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |-> !squash_o); // R3
  AST_SQUASH_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |=> !squash_o); // R9
  AST_ABORT_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> l_ptr == $past(l_ptr) - LPW'(1)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_err_o |=> stack_err_o); // R11
  AST_LOOP_IN_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    RPW'(l_ptr) <= r_ptr); // R12
  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (fetch_addr_o == RESET_ADDR) && !stack_err_o); // R1
endmodule

// File: tb/loop_seq_bench.sv
module loop_seq_bench;
  localparam int PERIOD = 10;
  localparam int NV     = 57;

  typedef struct packed {
    logic [2:0]  cmd;
    logic [1:0]  cs;
    logic [1:0]  ts;
    logic [15:0] addr;
    logic [15:0] ind;
    logic [15:0] cnt;
    logic        cond;
    logic [15:0] fa;
    logic        sq;
    logic        er;
    logic [3:0]  rq;
  } vec_t;

  function automatic vec_t v(int c, int cs, int ts, int a, int ind, int n, int cd,
                             int fa, int sq, int er, int rq);
    vec_t r;
    r.cmd = 3'(c);   r.cs = 2'(cs);   r.ts = 2'(ts);
    r.addr = 16'(a); r.ind = 16'(ind); r.cnt = 16'(n);
    r.cond = 1'(cd); r.fa = 16'(fa); r.sq = 1'(sq);
    r.er = 1'(er);   r.rq = 4'(rq);
    return r;
  endfunction

  // cmd: 0 nop 1 jump 2 call 3 rts 4 loop; cs: 0 always 1 cond 2 lce; ts: 0 dir 1 ind 2 rel
  localparam vec_t VEC [NV] = '{
    v(0,0,0,0,0,0,0,   0,0,0,2), v(0,0,0,0,0,0,0,   1,0,0,2),
    v(0,0,0,0,0,0,0,   2,0,0,2), v(0,0,0,0,0,0,0,   3,0,0,2),
    v(4,0,0,6,0,3,0,   4,0,0,3),                                // R3 loop 3..6 x3
    v(0,0,0,0,0,0,0,   5,0,0,2), v(0,0,0,0,0,0,0,   6,0,0,3),
    v(0,0,0,0,0,0,0,   3,0,0,3), v(0,0,0,0,0,0,0,   4,0,0,3),
    v(0,0,0,0,0,0,0,   5,0,0,3), v(0,0,0,0,0,0,0,   6,0,0,3),
    v(0,0,0,0,0,0,0,   3,0,0,3), v(0,0,0,0,0,0,0,   4,0,0,3),
    v(0,0,0,0,0,0,0,   5,0,0,3), v(0,0,0,0,0,0,0,   6,0,0,3),
    v(0,0,0,0,0,0,0,   7,0,0,4), v(0,0,0,0,0,0,0,   8,0,0,2),
    v(2,0,0,40,0,0,0,  9,1,0,6),                                // R6 call
    v(0,0,0,0,0,0,0,  40,0,0,6), v(0,0,0,0,0,0,0,  41,0,0,2),
    v(0,0,0,0,0,0,0,  42,0,0,2), v(0,0,0,0,0,0,0,  43,0,0,2),
    v(3,0,0,0,0,0,0,  44,1,0,6),                                // R6 return
    v(0,0,0,0,0,0,0,   8,0,0,6), v(0,0,0,0,0,0,0,   9,0,0,2),
    v(0,0,0,0,0,0,0,  10,0,0,2),
    v(4,0,0,13,0,1,0, 11,0,0,4),                                // R4 count 1
    v(0,0,0,0,0,0,0,  12,0,0,4), v(0,0,0,0,0,0,0,  13,0,0,4),
    v(0,0,0,0,0,0,0,  14,0,0,4),
    v(1,1,2,10,0,0,0, 15,0,0,8),                                // R8 not taken
    v(1,1,2,10,0,0,1, 16,1,0,7),                                // R7 relative
    v(0,0,0,0,0,0,0,  24,0,0,7), v(0,0,0,0,0,0,0,  25,0,0,2),
    v(1,0,1,0,100,0,0, 26,1,0,7),                               // R7 indirect
    v(0,0,0,0,0,0,0, 100,0,0,7), v(0,0,0,0,0,0,0, 101,0,0,2),
    v(4,0,0,110,0,2,0, 102,0,0,5),                              // R5 outer
    v(4,0,0,105,0,2,0, 103,0,0,5),                              // R5 inner
    v(0,0,0,0,0,0,0, 104,0,0,5), v(0,0,0,0,0,0,0, 105,0,0,5),
    v(0,0,0,0,0,0,0, 102,0,0,5), v(0,0,0,0,0,0,0, 103,0,0,5),
    v(0,0,0,0,0,0,0, 104,0,0,5), v(0,0,0,0,0,0,0, 105,0,0,5),
    v(0,0,0,0,0,0,0, 106,0,0,5), v(0,0,0,0,0,0,0, 107,0,0,5),
    v(0,0,0,0,0,0,0, 108,0,0,5), v(0,0,0,0,0,0,0, 109,0,0,5),
    v(0,0,0,0,0,0,0, 110,0,0,5), v(0,0,0,0,0,0,0, 101,0,0,5),
    v(0,0,0,0,0,0,0, 102,0,0,5),
    v(1,0,0,200,0,0,0, 103,1,0,10),                             // R10 abort
    v(0,0,0,0,0,0,0, 200,0,0,10), v(0,0,0,0,0,0,0, 201,0,0,10),
    v(3,0,0,0,0,0,0, 202,0,0,10),                               // R10 stack emptied
    v(0,0,0,0,0,0,0, 203,0,1,11)                                // R11 sticky
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic [1:0]  csel_i = '0;
  logic [1:0]  tsel_i = '0;
  logic [15:0] addr_i = '0;
  logic [15:0] ind_addr_i = '0;
  logic [15:0] count_i = '0;
  logic        cond_i = 1'b0;
  logic [15:0] fetch_addr_o;
  logic        squash_o;
  logic        stack_err_o;

  int checks = 0;
  int errors = 0;

  loop_seq u_loop_seq (
    .clk_i, .rst_ni, .cmd_i, .csel_i, .tsel_i, .addr_i, .ind_addr_i,
    .count_i, .cond_i, .fetch_addr_o, .squash_o, .stack_err_o
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drv(int c, int cs, int ts, int a, int ind, int n, int cd);
    cmd_i = 3'(c); csel_i = 2'(cs); tsel_i = 2'(ts);
    addr_i = 16'(a); ind_addr_i = 16'(ind); count_i = 16'(n); cond_i = 1'(cd);
  endtask

  task automatic step();
    @(negedge clk_i);
    drv(0,0,0,0,0,0,0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    drv(0,0,0,0,0,0,0);
    repeat (2) @(negedge clk_i);
    chk("R1 fetch", 32'(fetch_addr_o), 0);
    chk("R1 squash", 32'(squash_o), 0);
    chk("R1 err", 32'(stack_err_o), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    do_reset();
    // table walk: one row per cycle
    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d row%0d", VEC[i].rq, i);
      chk(tag, 32'(fetch_addr_o), 32'(VEC[i].fa));
      chk(tag, 32'(stack_err_o), 32'(VEC[i].er));
      drv(VEC[i].cmd, VEC[i].cs, VEC[i].ts, VEC[i].addr, VEC[i].ind, VEC[i].cnt, VEC[i].cond);
      #1;
      chk(tag, 32'(squash_o), 32'(VEC[i].sq));
      step();
    end

    // R8: loop-expired condition true, jump aborts loop
    do_reset();
    step(); step();
    drv(4,0,0,8,0,1,0); step();
    drv(1,2,0,50,0,0,0); #1; chk("R8 lce taken", 32'(squash_o), 1); step();
    chk("R10 target", 32'(fetch_addr_o), 50);
    drv(1,0,0,77,0,0,0); #1; chk("R9 squashed slot", 32'(squash_o), 0); step();
    chk("R9 squashed slot fetch", 32'(fetch_addr_o), 51);
    step();
    drv(3,0,0,0,0,0,0); #1; chk("R10 abort popped", 32'(squash_o), 0); step();
    chk("R11 underflow", 32'(stack_err_o), 1);

    // R8: loop-expired condition false
    do_reset();
    step(); step();
    drv(4,0,0,8,0,2,0); step();
    drv(1,2,0,50,0,0,0); #1; chk("R8 lce not taken", 32'(squash_o), 0); step();
    chk("R8 sequential", 32'(fetch_addr_o), 4);

    // R12 / R11: fill the return stack, overflow, unwind
    do_reset();
    step(); step();
    for (int i = 0; i < 31; i++) begin
      if (i == 30) chk("R12 thirty fit", 32'(stack_err_o), 0);
      drv(2,0,0,16'h80,0,0,0); #1; chk("R6 call squash", 32'(squash_o), 1);
      step(); step(); step();
    end
    chk("R11 overflow", 32'(stack_err_o), 1);
    for (int i = 0; i < 30; i++) begin
      drv(3,0,0,0,0,0,0); #1; chk("R6 rts squash", 32'(squash_o), 1);
      step();
      chk("R12 return addr", 32'(fetch_addr_o), (i == 29) ? 32'h1 : 32'h81);
      step(); step();
    end
    drv(3,0,0,0,0,0,0); #1; chk("R11 empty rts", 32'(squash_o), 0);
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule